// File: doc/BRIEF.md
# Load-PC Stride Prefetch Engine

This block observes load instructions, one per cycle at most, as pairs of program counter and accessed byte address. It keeps a small direct-mapped table keyed by the load's program counter. For each load it learns the distance between successive addresses and a confidence score for that distance. Once a load has shown the same nonzero distance often enough, each further observation of it launches a burst of prefetch addresses. The burst can start several strides ahead of the current access. It covers one to four consecutive stride steps, so the engine runs ahead of the demand stream instead of only guessing the next access.

Prefetch addresses are rounded down to the start of a cache block. A candidate equal to the block most recently queued is skipped. Accepted candidates wait in a small queue that drains through a valid/ready handshake. The observation port never stalls: when the queue is full, new candidates are discarded. Lookahead distance and burst size are runtime inputs.

Top module: `stride_pf_top`

## Requirements
- R1: After reset every table entry is empty and `pf_valid` is low until a prefetch has been produced.
- R2: The first observation of a load PC allocates its entry with stride 0 and confidence 0. A load stepping by a constant nonzero stride produces its first prefetch on its fourth observation, and observations before that produce none.
- R3: Confidence is a 2-bit saturating counter. A new stride equal to the stored one raises it. A differing stride lowers it and keeps the stored stride, unless confidence is already 0, in which case the new stride replaces the stored one. A burst starts when the updated confidence is 2 or more.
- R4: The burst for an observation at address A with stride S and distance D holds A + (D+k)·S for k = 0 … degree−1, issued in increasing k, with 32-bit wraparound. Negative strides are valid, and a distance input of 0 acts as 1.
- R5: The burst size comes from `cfg_degree`: the value 0 acts as 1 and values above 4 act as 4.
- R6: Every prefetch address has its low 6 bits cleared, which gives 64-byte blocks.
- R7: A candidate whose block equals the most recently queued block is not queued. This also applies to the first candidate of a new burst.
- R8: A load whose learned stride is 0 never produces a prefetch, whatever its confidence.
- R9: The entry index is PC bits [5:2]. The tag is all remaining PC bits. A load with a different tag at the same index replaces the entry and restarts training from the R2 state.
- R10: The output queue holds 4 addresses. While `pf_valid` is high and `pf_ready` is low, `pf_addr` holds steady. Candidates produced while the queue is full are discarded, and the observation port has no back-pressure.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| obs_valid | input | 1 | A load observation is present this cycle |
| obs_pc | input | 32 | Program counter of the observed load |
| obs_addr | input | 32 | Byte address accessed by the load |
| cfg_distance | input | 4 | Lookahead distance in strides (0 acts as 1) |
| cfg_degree | input | 3 | Prefetches per trigger (0 acts as 1, above 4 acts as 4) |
| pf_valid | output | 1 | A prefetch address is offered |
| pf_ready | input | 1 | Consumer accepts the offered address |
| pf_addr | output | 32 | Block-aligned prefetch address |

## Verification
The engine is trained with several kinds of address streams. An ascending stream with a stride of four blocks shows the fourth-observation start and how distance and degree place the burst. A 16-byte stride shows block merging and duplicate suppression. A descending, unaligned stream shows negative arithmetic and rounding. A repeated single address shows that a zero stride stays silent. A stream that breaks its stride for several loads, and a conflicting PC at the same index, show the gradual decay of confidence and the loss of training. A stalled consumer separates the four queued addresses from those discarded when the queue is full, and out-of-range configuration values show the clamping.

// File: rtl/spf_pkg.sv
// Package for the stride prefetch engine.
// Holds the confidence counter type and its saturating update helpers.
// Assumes the confidence width stays small (a few bits).
package spf_pkg;
    localparam int CONF_W    = 2;
    localparam int CONF_TRIG = 2;

    typedef logic [CONF_W-1:0] conf_t;

    localparam conf_t CONF_MAX = '1;

    // Saturating increment of a confidence value.
    function automatic conf_t conf_up(conf_t c);
        return (c == CONF_MAX) ? c : c + conf_t'(1);
    endfunction

    // Saturating decrement of a confidence value.
    function automatic conf_t conf_down(conf_t c);
        return (c == conf_t'(0)) ? c : c - conf_t'(1);
    endfunction
endpackage

// File: rtl/spf_table.sv
// Direct-mapped training table keyed by load PC.
// Each entry keeps a tag, the last address, the stride and a confidence value.
// It updates on every valid observation and flags a trigger, combinationally
// in the same cycle, when the updated entry is confident with a nonzero stride.
// Assumes PC bits [IDX_W+1:2] form the index. All other PC bits form the tag.
module spf_table
    import spf_pkg::*;
#(
    parameter int PC_W    = 32,
    parameter int ADDR_W  = 32,
    parameter int ENTRIES = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              obs_valid,
    input  logic [PC_W-1:0]   obs_pc,
    input  logic [ADDR_W-1:0] obs_addr,
    output logic              trig,
    output logic [ADDR_W-1:0] trig_stride
);
    localparam int IDX_W = $clog2(ENTRIES);
    localparam int TAG_W = PC_W - IDX_W;

    logic              vld_q  [ENTRIES];
    logic [TAG_W-1:0]  tag_q  [ENTRIES];
    logic [ADDR_W-1:0] last_q [ENTRIES];
    logic [ADDR_W-1:0] str_q  [ENTRIES];
    conf_t             conf_q [ENTRIES];

    logic [IDX_W-1:0]  idx;
    logic [TAG_W-1:0]  tag;
    logic              hit;
    logic [ADDR_W-1:0] new_str;
    logic [ADDR_W-1:0] nxt_str;
    conf_t             nxt_conf;

    // Decode the lookup and compute the next stride and confidence.
    always_comb begin
        idx     = obs_pc[IDX_W+1:2];
        tag     = {obs_pc[PC_W-1:IDX_W+2], obs_pc[1:0]};
        hit     = vld_q[idx] && (tag_q[idx] == tag);
        new_str = obs_addr - last_q[idx];
        if (new_str == str_q[idx]) begin
            nxt_conf = conf_up(conf_q[idx]);
            nxt_str  = str_q[idx];
        end else if (conf_q[idx] == conf_t'(0)) begin
            nxt_conf = conf_t'(0);
            nxt_str  = new_str;
        end else begin
            nxt_conf = conf_down(conf_q[idx]);
            nxt_str  = str_q[idx];
        end
        trig        = obs_valid && hit && (nxt_conf >= conf_t'(CONF_TRIG))
                      && (nxt_str != '0);
        trig_stride = nxt_str;
    end

    // Allocate on a miss and train on a hit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < ENTRIES; i++) begin
                vld_q[i]  <= 1'b0;
                tag_q[i]  <= '0;
                last_q[i] <= '0;
                str_q[i]  <= '0;
                conf_q[i] <= '0;
            end
        end else if (obs_valid) begin
            vld_q[idx]  <= 1'b1;
            tag_q[idx]  <= tag;
            last_q[idx] <= obs_addr;
            str_q[idx]  <= hit ? nxt_str : '0;
            conf_q[idx] <= hit ? nxt_conf : conf_t'(0);
        end
    end
endmodule

// File: rtl/spf_issue.sv
// Burst sequencer. On a trigger it loads the first target (address plus
// distance times stride) and then walks one stride per cycle for 'degree'
// cycles. Each candidate is rounded down to its block. A candidate is pushed
// unless it repeats the last pushed block or the queue is full, in which case
// it is dropped. A new trigger abandons the rest of an earlier burst.
module spf_issue #(
    parameter int ADDR_W  = 32,
    parameter int BLK_W   = 6,
    parameter int DIST_W  = 4,
    parameter int MAX_DEG = 4,
    parameter int DEG_W   = $clog2(MAX_DEG + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              trig,
    input  logic [ADDR_W-1:0] base_addr,
    input  logic [ADDR_W-1:0] stride,
    input  logic [DIST_W-1:0] cfg_distance,
    input  logic [DEG_W-1:0]  cfg_degree,
    input  logic              q_full,
    output logic              push,
    output logic [ADDR_W-1:0] push_addr
);
    localparam logic [ADDR_W-1:0] BLK_MASK = ~((ADDR_W'(1) << BLK_W) - ADDR_W'(1));

    logic [ADDR_W-1:0] cur_q, str_q, last_blk_q;
    logic              last_vld_q;
    logic [DEG_W-1:0]  cnt_q;
    logic [DIST_W-1:0] dist_eff;
    logic [DEG_W-1:0]  deg_eff;
    logic [ADDR_W-1:0] first_tgt;
    logic [ADDR_W-1:0] cand;
    logic              dup;

    // Clamp the configuration and form the first target and the current candidate.
    always_comb begin
        dist_eff  = (cfg_distance == '0) ? DIST_W'(1) : cfg_distance;
        if (cfg_degree == '0)
            deg_eff = DEG_W'(1);
        else if (cfg_degree > DEG_W'(MAX_DEG))
            deg_eff = DEG_W'(MAX_DEG);
        else
            deg_eff = cfg_degree;
        first_tgt = base_addr + ({{(ADDR_W-DIST_W){1'b0}}, dist_eff} * stride);
        cand      = cur_q & BLK_MASK;
        dup       = last_vld_q && (cand == last_blk_q);
        push      = (cnt_q != '0) && !dup && !q_full;
        push_addr = cand;
    end

    // Step the burst and remember the most recently pushed block.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_q      <= '0;
            str_q      <= '0;
            cnt_q      <= '0;
            last_blk_q <= '0;
            last_vld_q <= 1'b0;
        end else begin
            if (trig) begin
                cur_q <= first_tgt;
                str_q <= stride;
                cnt_q <= deg_eff;
            end else if (cnt_q != '0) begin
                cur_q <= cur_q + str_q;
                cnt_q <= cnt_q - DEG_W'(1);
            end
            if (push) begin
                last_blk_q <= cand;
                last_vld_q <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/spf_queue.sv
// Small output FIFO with a valid/ready read side. A write arriving while the
// FIFO is full is discarded, even if a read happens in the same cycle.
// Assumes DEPTH is a power of two so that the pointers wrap naturally.
module spf_queue #(
    parameter int W     = 32,
    parameter int DEPTH = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_en,
    input  logic [W-1:0]             wr_data,
    output logic                     full,
    output logic [$clog2(DEPTH):0]   level,
    output logic                     rd_valid,
    input  logic                     rd_ready,
    output logic [W-1:0]             rd_data
);
    localparam int PTR_W = $clog2(DEPTH);

    logic [W-1:0]     mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr, rd_ptr;
    logic [PTR_W:0]   cnt;
    logic             do_wr, do_rd;

    // Derive the handshake flags from the fill count.
    always_comb begin
        full     = (cnt == (PTR_W+1)'(DEPTH));
        level    = cnt;
        rd_valid = (cnt != '0);
        rd_data  = mem[rd_ptr];
        do_wr    = wr_en && !full;
        do_rd    = rd_valid && rd_ready;
    end

    // Advance the pointers and the count, and store written data.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            cnt    <= '0;
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else begin
            if (do_wr) begin
                mem[wr_ptr] <= wr_data;
                wr_ptr      <= wr_ptr + PTR_W'(1);
            end
            if (do_rd) rd_ptr <= rd_ptr + PTR_W'(1);
            cnt <= cnt + (PTR_W+1)'(do_wr) - (PTR_W+1)'(do_rd);
        end
    end
endmodule

// File: rtl/stride_pf_top.sv
// Top of the load-PC stride prefetch engine. It chains the training table,
// the burst sequencer and the output queue. Observations are accepted every
// cycle. Prefetch addresses leave through a valid/ready port.
module stride_pf_top #(
    parameter int PC_W    = 32,
    parameter int ADDR_W  = 32,
    parameter int ENTRIES = 16,
    parameter int BLK_W   = 6,
    parameter int DIST_W  = 4,
    parameter int MAX_DEG = 4,
    parameter int QDEPTH  = 4,
    parameter int DEG_W   = $clog2(MAX_DEG + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              obs_valid,
    input  logic [PC_W-1:0]   obs_pc,
    input  logic [ADDR_W-1:0] obs_addr,
    input  logic [DIST_W-1:0] cfg_distance,
    input  logic [DEG_W-1:0]  cfg_degree,
    output logic              pf_valid,
    input  logic              pf_ready,
    output logic [ADDR_W-1:0] pf_addr
);
    logic                      tbl_trig;
    logic [ADDR_W-1:0]         tbl_stride;
    logic                      gen_push;
    logic [ADDR_W-1:0]         gen_addr;
    logic                      q_full;
    logic [$clog2(QDEPTH):0]   q_level;

    spf_table #(.PC_W(PC_W), .ADDR_W(ADDR_W), .ENTRIES(ENTRIES)) u_table (
        .clk(clk), .rst_n(rst_n), .obs_valid(obs_valid), .obs_pc(obs_pc),
        .obs_addr(obs_addr), .trig(tbl_trig), .trig_stride(tbl_stride)
    );

    spf_issue #(.ADDR_W(ADDR_W), .BLK_W(BLK_W), .DIST_W(DIST_W),
                .MAX_DEG(MAX_DEG), .DEG_W(DEG_W)) u_issue (
        .clk(clk), .rst_n(rst_n), .trig(tbl_trig), .base_addr(obs_addr),
        .stride(tbl_stride), .cfg_distance(cfg_distance), .cfg_degree(cfg_degree),
        .q_full(q_full), .push(gen_push), .push_addr(gen_addr)
    );

    spf_queue #(.W(ADDR_W), .DEPTH(QDEPTH)) u_queue (
        .clk(clk), .rst_n(rst_n), .wr_en(gen_push), .wr_data(gen_addr),
        .full(q_full), .level(q_level), .rd_valid(pf_valid),
        .rd_ready(pf_ready), .rd_data(pf_addr)
    );
endmodule

// File: rtl/stride_pf_chk.sv
// Property checker for the stride prefetch engine, bound to its top.
// It watches the ports and the internal handoffs between the submodules.
module stride_pf_chk #(
    parameter int ADDR_W  = 32,
    parameter int BLK_W   = 6,
    parameter int MAX_DEG = 4,
    parameter int QDEPTH  = 4
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    pf_valid,
    input logic                    pf_ready,
    input logic [ADDR_W-1:0]       pf_addr,
    input logic                    trig,
    input logic                    push,
    input logic [ADDR_W-1:0]       push_addr,
    input logic [$clog2(QDEPTH):0] level
);
    logic [ADDR_W-1:0] prev_push_q;
    logic              prev_vld_q;
    logic [7:0]        burst_cnt_q;

    // Track the last pushed block and the number of pushes since the last trigger.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_push_q <= '0;
            prev_vld_q  <= 1'b0;
            burst_cnt_q <= '0;
        end else begin
            if (push) begin
                prev_push_q <= push_addr;
                prev_vld_q  <= 1'b1;
            end
            if (trig) burst_cnt_q <= '0;
            else if (push) burst_cnt_q <= burst_cnt_q + 8'd1;
        end
    end

    AST_RESET_IDLE: assert property (@(posedge clk) !rst_n |=> !pf_valid); // R1
    AST_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
        pf_valid |-> (pf_addr[BLK_W-1:0] == '0)); // R6
    AST_NO_REPEAT: assert property (@(posedge clk) disable iff (!rst_n)
        (push && prev_vld_q) |-> (push_addr != prev_push_q)); // R7
    AST_BURST_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        burst_cnt_q <= 8'(MAX_DEG)); // R5
    AST_HOLD_STALL: assert property (@(posedge clk) disable iff (!rst_n)
        (pf_valid && !pf_ready) |=> (pf_valid && $stable(pf_addr))); // R10
    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        level <= ($clog2(QDEPTH)+1)'(QDEPTH)); // R10
endmodule

bind stride_pf_top stride_pf_chk #(
    .ADDR_W(ADDR_W), .BLK_W(BLK_W), .MAX_DEG(MAX_DEG), .QDEPTH(QDEPTH)
) chk_i (
    .clk(clk), .rst_n(rst_n), .pf_valid(pf_valid), .pf_ready(pf_ready),
    .pf_addr(pf_addr), .trig(tbl_trig), .push(gen_push), .push_addr(gen_addr),
    .level(q_level)
);

// File: tb/stride_pf_top_tb_top.sv
// Scoreboard bench. Driver tasks queue the expected prefetch addresses, and a
// monitor pops and compares them as the engine hands addresses out.
module stride_pf_top_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        obs_valid = 1'b0;
    logic [31:0] obs_pc = '0;
    logic [31:0] obs_addr = '0;
    logic [3:0]  cfg_distance = 4'd1;
    logic [2:0]  cfg_degree = 3'd1;
    logic        pf_valid;
    logic        pf_ready = 1'b1;
    logic [31:0] pf_addr;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    logic [31:0] exp_q[$];
    string       tag_q[$];

    always #10 clk = ~clk;

    stride_pf_top dut_i (
        .clk(clk), .rst_n(rst_n), .obs_valid(obs_valid), .obs_pc(obs_pc),
        .obs_addr(obs_addr), .cfg_distance(cfg_distance), .cfg_degree(cfg_degree),
        .pf_valid(pf_valid), .pf_ready(pf_ready), .pf_addr(pf_addr)
    );

    // Monitor: compare each accepted prefetch against the scoreboard.
    always @(negedge clk) begin
        if (rst_n && pf_valid && pf_ready) begin
            checks++;
            if (exp_q.size() == 0) begin
                failures++;
                $display("FAIL unexpected prefetch: actual %h expected none", pf_addr);
            end else begin
                logic [31:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                if (pf_addr !== e) begin
                    failures++;
                    $display("FAIL %s prefetch: actual %h expected %h", t, pf_addr, e);
                end
            end
        end
    end

    task automatic expect_pf(input logic [31:0] a, input string t);
        exp_q.push_back(a);
        tag_q.push_back(t);
    endtask

    task automatic observe(input logic [31:0] pc, input logic [31:0] a);
        @(posedge clk); #2;
        obs_valid = 1'b1; obs_pc = pc; obs_addr = a;
        @(posedge clk); #2;
        obs_valid = 1'b0;
        repeat (6) @(posedge clk);
    endtask

    task automatic check_drained(input string t);
        repeat (6) @(posedge clk);
        checks++;
        if (exp_q.size() != 0) begin
            failures++;
            $display("FAIL %s missing prefetches: actual %0d pending expected 0", t, exp_q.size());
            exp_q.delete(); tag_q.delete();
        end
    endtask

    task automatic check_idle(input string t);
        @(negedge clk);
        checks++;
        if (pf_valid !== 1'b0) begin
            failures++;
            $display("FAIL %s idle: actual pf_valid=%b expected 0", t, pf_valid);
        end
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        #(20 * 150000);
        if (!done) begin
            failures++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (4) @(posedge clk);
        #2 rst_n = 1'b1;
        check_idle("R1");

        // R2 / R4: ascending stride of 0x100, first prefetch on fourth load
        cfg_distance = 4'd1; cfg_degree = 3'd1;
        observe(32'h100, 32'h10000);
        observe(32'h100, 32'h10100);
        observe(32'h100, 32'h10200);
        check_idle("R2");
        expect_pf(32'h10400, "R2");
        observe(32'h100, 32'h10300);
        expect_pf(32'h10500, "R3");
        observe(32'h100, 32'h10400);
        check_drained("R2");

        // R4: lookahead distance 3
        cfg_distance = 4'd3;
        expect_pf(32'h10800, "R4");
        observe(32'h100, 32'h10500);
        // R4 / R5: degree 3
        cfg_distance = 4'd1; cfg_degree = 3'd3;
        expect_pf(32'h10700, "R5");
        expect_pf(32'h10800, "R5");
        expect_pf(32'h10900, "R5");
        observe(32'h100, 32'h10600);
        check_drained("R4");

        // R7: 16-byte stride, four candidates share one block
        cfg_degree = 3'd4;
        observe(32'h204, 32'h20000);
        observe(32'h204, 32'h20010);
        observe(32'h204, 32'h20020);
        expect_pf(32'h20040, "R7");
        observe(32'h204, 32'h20030);
        check_drained("R7");

        // R4 / R6: negative, unaligned stride
        cfg_degree = 3'd2;
        observe(32'h308, 32'h30024);
        observe(32'h308, 32'h2FFA4);
        observe(32'h308, 32'h2FF24);
        expect_pf(32'h2FE00, "R6");
        expect_pf(32'h2FD80, "R6");
        observe(32'h308, 32'h2FEA4);
        check_drained("R6");

        // R8: repeated address, zero stride
        for (int i = 0; i < 5; i++) observe(32'h40C, 32'h40000);
        check_idle("R8");

        // R3: mismatches decay confidence, stride replaced only at zero
        cfg_degree = 3'd1;
        expect_pf(32'h10740, "R3");
        observe(32'h100, 32'h10640);
        observe(32'h100, 32'h10680);
        observe(32'h100, 32'h106C0);
        observe(32'h100, 32'h10700);
        observe(32'h100, 32'h10740);
        check_idle("R3");
        expect_pf(32'h107C0, "R3");
        observe(32'h100, 32'h10780);
        check_drained("R3");

        // R9: conflicting tag at the same index restarts training
        observe(32'h140, 32'h90000);
        observe(32'h100, 32'h107C0);
        observe(32'h100, 32'h10800);
        observe(32'h100, 32'h10840);
        check_idle("R9");
        expect_pf(32'h108C0, "R9");
        observe(32'h100, 32'h10880);
        check_drained("R9");

        // R10: stalled consumer, queue holds 4, rest dropped
        cfg_degree = 3'd4;
        pf_ready = 1'b0;
        observe(32'h510, 32'h50000);
        observe(32'h510, 32'h50040);
        observe(32'h510, 32'h50080);
        observe(32'h510, 32'h500C0);
        observe(32'h510, 32'h50100);
        @(negedge clk);
        checks++;
        if (!(pf_valid === 1'b1 && pf_addr === 32'h50100)) begin
            failures++;
            $display("FAIL R10 stall hold: actual valid=%b addr=%h expected 1 50100", pf_valid, pf_addr);
        end
        expect_pf(32'h50100, "R10");
        expect_pf(32'h50140, "R10");
        expect_pf(32'h50180, "R10");
        expect_pf(32'h501C0, "R10");
        @(posedge clk); #2 pf_ready = 1'b1;
        check_drained("R10");
        check_idle("R10");

        // R5 / R4: degree 0 and distance 0 act as 1
        cfg_degree = 3'd0; cfg_distance = 4'd0;
        expect_pf(32'h50180, "R5");
        observe(32'h510, 32'h50140);
        check_drained("R5");
        // R5: degree 7 acts as 4
        cfg_degree = 3'd7; cfg_distance = 4'd1;
        expect_pf(32'h501C0, "R5");
        expect_pf(32'h50200, "R5");
        expect_pf(32'h50240, "R5");
        expect_pf(32'h50280, "R5");
        observe(32'h510, 32'h50180);
        check_drained("R5");
        check_idle("R5");

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule